// File: doc/BRIEF.md
# Multi-Locality Ownership Arbiter

This block decides which of five localities owns a security-module register interface. Each locality reaches its own ownership register through a simple byte read/write port. The locality is taken from a three-bit address field that sits just above the 4 KiB register page. Software in a locality can ask for ownership, give it up, clear its "was taken away" mark, or forcibly take ownership from a lower-numbered locality. A higher locality always wins. When the owner gives up, ownership goes to the highest locality that is waiting for it.

A handover is not always instant. If the execution unit reports a command in flight, the arbiter records the intended new owner and pulses a cancel request. It completes the switch only when the execution unit returns a done pulse. If nothing is executing, the switch happens in the same cycle as the write. The outputs are the current owner index with a valid flag, and a one-cycle interrupt pulse each time a locality gains ownership.

Top module: `loc_arbiter`

## Requirements
- R1: After reset no locality owns the interface, and a read of the ownership register of any locality 0..4 returns 0x80.
- R2: Address bits [14:12] select the locality and only offset 0 of the page (bits [11:0] all zero) is the ownership register. Any other offset, and any locality 5..7, reads 0x00 and ignores writes. Writes to locality 4 are ignored, while reads from locality 4 work normally.
- R3: The read image has these bits: bit 7 always set, bit 5 set when the reader owns the interface, bit 4 holding the taken-away mark, bit 2 set when any other locality has a waiting request, and bit 1 holding the reader's own waiting request. Bit 3, the internal forced-take flag, always reads 0.
- R4: Writing bit 1 from a non-owner sets its waiting request if some locality owns the interface. If none does, the writer becomes the owner at once.
- R5: When the owner writes bit 5, ownership passes to the highest-numbered locality with a waiting request, or to nobody if none is waiting.
- R6: When a non-owner writes bit 5, the only effect is that its own waiting request is cleared.
- R7: Writing 1 to bit 4 clears the writer's taken-away mark.
- R8: A write with bit 3 (forced take) is accepted only if nobody owns the interface or the writer's index is above the owner's. It is ignored if the writer already has a forced take pending, or if a higher locality has one pending. An accepted forced take cancels pending forced takes of all lower localities.
- R9: In a write that carries bit 3, bits 1 and 5 have no effect.
- R10: On an ownership change, the old owner loses ownership and also loses its waiting request, unless the new owner came in by forced take; in that case its taken-away mark is set instead. The new owner's waiting request and forced-take flag are cleared. owner_chg_irq pulses for one cycle after the switch when a locality gains ownership, and does not pulse when ownership goes to nobody.
- R11: If exec_busy is high when a handover starts, exec_cancel pulses in the next cycle and ownership does not change until an exec_done pulse arrives. At that point the switch to the recorded locality completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe; data appears on bus_rdata after the next edge |
| bus_addr | input | 15 | Byte address: locality in [14:12], page offset in [11:0] |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| exec_busy | input | 1 | A command is executing somewhere |
| exec_done | input | 1 | One-cycle pulse that ends the execution being waited on |
| exec_cancel | output | 1 | One-cycle request to cancel the executing command |
| owner_valid | output | 1 | Some locality owns the interface |
| owner_idx | output | 3 | Index of the owning locality |
| owner_chg_irq | output | 1 | One-cycle pulse when a locality gains ownership |

## Verification
Several invariants are checked on every cycle. The owner never carries a waiting request or a forced-take flag. At most one forced take is pending at a time. Every interrupt pulse lines up with a real change to a valid owner. Writes aimed at locality 4 leave the state untouched, and ownership stays frozen while a handover waits for exec_done. Other behaviour can only be shown by the bench's scenarios: the priority order among waiting requesters, the rules for rejecting a forced take, the masking of bits that share a write with a forced take, and the exact read images. These are covered by directed sequences and by a long pseudo-random run of writes, reads, busy toggles and done pulses, compared against an independent model.

// File: rtl/la_pkg.sv
package la_pkg;
  localparam int NLOC    = 5;
  localparam int LW      = $clog2(NLOC);
  localparam int LOC_LSB = 12;
  localparam int LOC_FW  = 3;
  localparam int ADDR_W  = LOC_LSB + LOC_FW;

  // ownership register bit positions
  localparam int B_REQ   = 1;
  localparam int B_PEND  = 2;
  localparam int B_SEIZE = 3;
  localparam int B_BEEN  = 4;
  localparam int B_ACT   = 5;
  localparam int B_VALID = 7;

  localparam logic [7:0] HELD_NONE = 8'hFF;

  typedef struct packed {
    logic [NLOC-1:0] req;
    logic [NLOC-1:0] seize;
    logic [NLOC-1:0] been;
    logic            own_v;
    logic [LW-1:0]   own;
  } arb_t;

  // {found, index} of the highest set bit
  function automatic logic [LW:0] top_req(input logic [NLOC-1:0] v);
    logic [LW:0] r;
    r = '0;
    for (int i = 0; i < NLOC; i++)
      if (v[i]) r = {1'b1, LW'(i)};
    return r;
  endfunction

  function automatic logic seize_above(input logic [NLOC-1:0] s, input logic [LW-1:0] l);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NLOC; i++)
      if (i > int'(l) && s[i]) r = 1'b1;
    return r;
  endfunction

  function automatic logic [NLOC-1:0] below_mask(input logic [LW-1:0] l);
    logic [NLOC-1:0] m;
    for (int i = 0; i < NLOC; i++) m[i] = (i < int'(l));
    return m;
  endfunction

  function automatic logic [7:0] acc_image(input arb_t s, input logic [LW-1:0] l);
    logic [7:0]      img;
    logic [NLOC-1:0] others;
    others = s.req;
    others[l] = 1'b0;
    img = '0;
    img[B_VALID] = 1'b1;
    img[B_ACT]   = s.own_v && (s.own == l);
    img[B_BEEN]  = s.been[l];
    img[B_PEND]  = |others;
    img[B_REQ]   = s.req[l];
    return img;
  endfunction

  // apply an ownership change to nv/n (nv=0: nobody)
  function automatic arb_t switch_owner(input arb_t s, input logic nv,
                                        input logic [LW-1:0] n, output logic irq);
    arb_t r;
    logic change;
    logic forced;
    r = s;
    change = (nv != s.own_v) || (nv && (n != s.own));
    if (change && s.own_v) begin
      forced = nv && s.seize[n];
      if (forced) r.been[s.own] = 1'b1;
      else        r.req[s.own]  = 1'b0;
    end
    r.own_v = nv;
    r.own   = nv ? n : '0;
    if (nv) begin
      r.req[n]   = 1'b0;
      r.seize[n] = 1'b0;
    end
    irq = change && nv;
    return r;
  endfunction
endpackage

// File: rtl/la_decode.sv
module la_decode
  import la_pkg::*;
#(
  parameter int BLOCKED_LOC = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [LW-1:0]     loc,
  output logic              loc_ok,
  output logic              acc_hit,
  output logic              wr_ok
);
  localparam logic [LOC_FW-1:0] NLOC_F = LOC_FW'(NLOC);
  localparam logic [LOC_FW-1:0] BLK_F  = LOC_FW'(BLOCKED_LOC);

  logic [LOC_FW-1:0] field;

  assign field   = addr[ADDR_W-1:LOC_LSB];
  assign loc     = field[LW-1:0];
  assign loc_ok  = field < NLOC_F;
  assign acc_hit = addr[LOC_LSB-1:0] == '0;
  assign wr_ok   = loc_ok && (field != BLK_F);
endmodule

// File: rtl/la_handover.sv
module la_handover
  import la_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [LW-1:0] arm_idx,
  input  logic          drop,
  output logic          waiting,
  output logic [LW-1:0] held_idx,
  output logic          cancel_req
);
  logic [7:0] held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held       <= HELD_NONE;
      cancel_req <= 1'b0;
    end else begin
      cancel_req <= arm;
      if (arm)       held <= 8'(arm_idx);
      else if (drop) held <= HELD_NONE;
    end
  end

  assign waiting  = held != HELD_NONE;
  assign held_idx = held[LW-1:0];

  a_r11_cancel_follows_arm: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> cancel_req);
  a_r11_held_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> (held < 8'(NLOC)));
endmodule

// File: rtl/la_readback.sv
module la_readback
  import la_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          loc_ok,
  input  logic          acc_hit,
  input  logic [LW-1:0] loc,
  input  arb_t          st,
  output logic [7:0]    rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= (loc_ok && acc_hit) ? acc_image(st, loc) : 8'h00;
  end

  a_r3_valid_bit_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && loc_ok && acc_hit) |=> rdata[B_VALID]);
  a_r2_other_offset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !acc_hit) |=> (rdata == 8'h00));
endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter
  import la_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              exec_busy,
  input  logic              exec_done,
  output logic              exec_cancel,
  output logic              owner_valid,
  output logic [LW-1:0]     owner_idx,
  output logic              owner_chg_irq
);
  arb_t st, st_n;
  logic [$bits(arb_t)-1:0] st_bits;

  logic [LW-1:0] d_loc;
  logic          d_ok, d_acc, d_wok;
  logic          wr_hit;
  logic          waiting;
  logic [LW-1:0] held_idx;
  logic          done_fire;
  logic          ho;
  logic [LW-1:0] ho_idx;
  logic          arm, drop;
  logic          irq_n;

  la_decode #(.BLOCKED_LOC(4)) u_dec (
    .addr(bus_addr), .loc(d_loc), .loc_ok(d_ok), .acc_hit(d_acc), .wr_ok(d_wok)
  );

  assign wr_hit    = bus_wr && d_wok && d_acc;
  assign done_fire = waiting && exec_done;

  always_comb begin
    arb_t          s;
    logic [7:0]    v;
    logic          i_a, i_b, i_c;
    logic          set_new;
    logic          tv;
    logic [LW-1:0] tgt;
    logic [LW:0]   hr;
    s = st;
    i_a = 1'b0; i_b = 1'b0; i_c = 1'b0;
    ho = 1'b0; ho_idx = '0;
    v = bus_wdata; set_new = 1'b1; tv = 1'b0; tgt = '0; hr = '0;
    // a completed execution finishes the recorded handover first
    if (done_fire) s = switch_owner(s, 1'b1, held_idx, i_a);
    if (wr_hit) begin
      if (v[B_SEIZE]) begin
        v[B_REQ] = 1'b0;
        v[B_ACT] = 1'b0;
      end
      tv  = s.own_v;
      tgt = s.own;
      if (v[B_ACT]) begin
        if (s.own_v && s.own == d_loc) begin
          hr = top_req(s.req);
          if (hr[LW]) begin
            set_new = 1'b0;
            ho      = 1'b1;
            ho_idx  = hr[LW-1:0];
          end else begin
            tv = 1'b0;
          end
        end else begin
          s.req[d_loc] = 1'b0;
        end
      end
      if (v[B_BEEN]) s.been[d_loc] = 1'b0;
      if (v[B_SEIZE]) begin
        if ((!s.own_v || d_loc > s.own) && !s.seize[d_loc] &&
            !seize_above(s.seize, d_loc)) begin
          s.seize        = s.seize & ~below_mask(d_loc);
          s.seize[d_loc] = 1'b1;
          set_new        = 1'b0;
          ho             = 1'b1;
          ho_idx         = d_loc;
        end
      end
      if (v[B_REQ] && !(s.own_v && s.own == d_loc)) begin
        if (s.own_v) s.req[d_loc] = 1'b1;
        else begin
          tv  = 1'b1;
          tgt = d_loc;
        end
      end
      if (set_new) s = switch_owner(s, tv, tgt, i_b);
      if (ho && !exec_busy) s = switch_owner(s, 1'b1, ho_idx, i_c);
    end
    st_n  = s;
    irq_n = i_a | i_b | i_c;
  end

  assign arm  = ho && exec_busy;
  assign drop = done_fire || (ho && !exec_busy);

  la_handover u_ho (
    .clk(clk), .rst_n(rst_n), .arm(arm), .arm_idx(ho_idx), .drop(drop),
    .waiting(waiting), .held_idx(held_idx), .cancel_req(exec_cancel)
  );

  la_readback u_rb (
    .clk(clk), .rst_n(rst_n), .rd_en(bus_rd), .loc_ok(d_ok), .acc_hit(d_acc),
    .loc(d_loc), .st(st), .rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= '0;
      owner_chg_irq <= 1'b0;
    end else begin
      st            <= st_n;
      owner_chg_irq <= irq_n;
    end
  end

  assign owner_valid = st.own_v;
  assign owner_idx   = st.own;
  assign st_bits     = st;

  a_r10_owner_clean: assert property (@(posedge clk) disable iff (!rst_n)
    owner_valid |-> (!st.req[owner_idx] && !st.seize[owner_idx]));
  a_r8_single_seize: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(st.seize));
  a_r10_irq_has_owner: assert property (@(posedge clk) disable iff (!rst_n)
    owner_chg_irq |-> owner_valid);
  a_r10_irq_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    owner_chg_irq |-> (!$past(owner_valid) || owner_idx != $past(owner_idx)));
  a_r2_loc4_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[ADDR_W-1:LOC_LSB] == 3'd4 && !done_fire) |=> $stable(st_bits));
  a_r11_hold_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !exec_done && !bus_wr) |=> ($stable(owner_valid) && $stable(owner_idx)));
endmodule

// File: tb/tb_loc_arbiter.sv
`timescale 1ns/100ps
module tb_loc_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [14:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        exec_busy = 1'b0, exec_done = 1'b0;
  logic        exec_cancel, owner_valid, owner_chg_irq;
  logic [2:0]  owner_idx;

  always #2.5 clk = ~clk;

  loc_arbiter dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .exec_busy(exec_busy),
    .exec_done(exec_done), .exec_cancel(exec_cancel), .owner_valid(owner_valid),
    .owner_idx(owner_idx), .owner_chg_irq(owner_chg_irq)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // independent reference state
  int mreq[5], msz[5], mbeen[5];
  int mown = -1, mheld = -1;
  bit mirq, mcancel;
  bit last_irq, last_cancel;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic void m_switch(input int n);
    bit ch;
    ch = (n != mown);
    if (ch && mown >= 0) begin
      if (n >= 0 && msz[n] != 0) mbeen[mown] = 1;
      else mreq[mown] = 0;
    end
    mown = n;
    if (n >= 0) begin mreq[n] = 0; msz[n] = 0; end
    if (ch && n >= 0) mirq = 1;
  endfunction

  function automatic void m_write(input int l, input int v, input bit busy);
    bit sz, rq, ac, setn, hi;
    int ho, tv;
    mirq = 0; mcancel = 0;
    if (l >= 4) return;
    sz = v[3]; rq = v[1] && !sz; ac = v[5] && !sz;
    ho = -1; tv = mown; setn = 1;
    if (ac) begin
      if (mown == l) begin
        int c;
        c = -1;
        for (int k = 4; k >= 0; k--) if (c < 0 && mreq[k] != 0) c = k;
        if (c >= 0) begin setn = 0; ho = c; end
        else tv = -1;
      end else mreq[l] = 0;
    end
    if (v[4]) mbeen[l] = 0;
    if (sz) begin
      hi = 0;
      for (int k = l + 1; k < 5; k++) if (msz[k] != 0) hi = 1;
      if ((mown < 0 || l > mown) && msz[l] == 0 && !hi) begin
        for (int k = 0; k < l; k++) msz[k] = 0;
        msz[l] = 1; setn = 0; ho = l;
      end
    end
    if (rq && mown != l) begin
      if (mown >= 0) mreq[l] = 1;
      else tv = l;
    end
    if (setn) m_switch(tv);
    if (ho >= 0) begin
      if (busy) begin mheld = ho; mcancel = 1; end
      else begin m_switch(ho); mheld = -1; end
    end
  endfunction

  function automatic int m_image(input int l, input int off);
    int img, pend;
    if (l >= 5 || off != 0) return 0;
    pend = 0;
    for (int k = 0; k < 5; k++) if (k != l && mreq[k] != 0) pend = 1;
    img = 128 + ((mown == l) ? 32 : 0) + 16 * mbeen[l] + 4 * pend + 2 * mreq[l];
    return img;
  endfunction

  task automatic chk_owner(input string tag);
    chk(owner_valid == (mown >= 0), tag, owner_valid, mown >= 0);
    if (mown >= 0) chk(int'(owner_idx) == mown, tag, owner_idx, mown);
  endtask

  task automatic do_write(input int l, input int off, input int v, input string tag);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 15'((l << 12) | off); bus_wdata = 8'(v);
    if (off == 0) m_write(l, v, exec_busy);
    else begin mirq = 0; mcancel = 0; end
    @(negedge clk);
    bus_wr = 1'b0;
    last_irq = owner_chg_irq; last_cancel = exec_cancel;
    chk(last_irq == mirq, {tag, " irq"}, last_irq, mirq);
    chk(last_cancel == mcancel, {tag, " cancel"}, last_cancel, mcancel);
    chk_owner({tag, " owner"});
  endtask

  task automatic do_read(input int l, input int off, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 15'((l << 12) | off);
    @(negedge clk);
    bus_rd = 1'b0;
    chk(int'(bus_rdata) == m_image(l, off), {tag, " read"}, bus_rdata, m_image(l, off));
  endtask

  task automatic do_done(input string tag);
    @(negedge clk);
    exec_done = 1'b1; mirq = 0;
    if (mheld >= 0) begin m_switch(mheld); mheld = -1; end
    @(negedge clk);
    exec_done = 1'b0;
    last_irq = owner_chg_irq;
    chk(last_irq == mirq, {tag, " irq"}, last_irq, mirq);
    chk_owner({tag, " owner"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit [31:0] x;
    for (int k = 0; k < 5; k++) begin mreq[k] = 0; msz[k] = 0; mbeen[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(owner_valid == 1'b0, "R1 no owner", owner_valid, 0);
    for (int l = 0; l < 5; l++) begin
      do_read(l, 0, "R1");
      chk(bus_rdata == 8'h80, "R1 image", bus_rdata, 8'h80);
    end
    do_read(5, 0, "R2 missing locality");
    // R4 request with nobody owning, then waiting requests
    do_write(1, 0, 8'h02, "R4");
    chk(last_irq == 1'b1 && owner_idx == 3'd1, "R4 immediate", owner_idx, 1);
    do_write(3, 0, 8'h02, "R4");
    do_read(3, 0, "R3");
    chk(bus_rdata == 8'h82, "R3 req bit", bus_rdata, 8'h82);
    do_read(0, 0, "R3");
    chk(bus_rdata == 8'h84, "R3 pending", bus_rdata, 8'h84);
    do_read(1, 0, "R3");
    chk(bus_rdata == 8'hA4, "R3 owner image", bus_rdata, 8'hA4);
    // R2 locality 4 and other offsets
    do_write(4, 0, 8'h02, "R2");
    do_read(4, 0, "R2");
    chk(bus_rdata == 8'h84, "R2 loc4 write ignored", bus_rdata, 8'h84);
    do_write(0, 4, 8'h02, "R2");
    do_read(0, 0, "R2");
    chk(bus_rdata == 8'h84, "R2 offset write ignored", bus_rdata, 8'h84);
    do_read(0, 4, "R2");
    // R6 non-owner active bit
    do_write(2, 0, 8'h02, "R4");
    do_write(2, 0, 8'h20, "R6");
    do_read(2, 0, "R6");
    chk(bus_rdata == 8'h84, "R6 own req cleared", bus_rdata, 8'h84);
    // R5 relinquish to highest
    do_write(2, 0, 8'h02, "R4");
    do_write(1, 0, 8'h20, "R5");
    chk(owner_idx == 3'd3 && last_irq, "R5 highest wins", owner_idx, 3);
    do_read(1, 0, "R10");
    do_write(3, 0, 8'h20, "R5");
    do_write(2, 0, 8'h20, "R5");
    chk(!owner_valid && !last_irq, "R5 to nobody", owner_valid, 0);
    // R9 / R8 rejected seize masks request
    do_write(2, 0, 8'h02, "R4");
    do_write(1, 0, 8'h2A, "R9");
    do_read(1, 0, "R9");
    chk(bus_rdata == 8'h80, "R9 req masked", bus_rdata, 8'h80);
    chk(owner_idx == 3'd2, "R8 lower seize rejected", owner_idx, 2);
    // R8/R10 accepted seize
    do_write(3, 0, 8'h08, "R8");
    chk(owner_idx == 3'd3 && last_irq, "R8 seize taken", owner_idx, 3);
    do_read(2, 0, "R10");
    chk(bus_rdata == 8'h90, "R10 been set", bus_rdata, 8'h90);
    do_write(2, 0, 8'h10, "R7");
    do_read(2, 0, "R7");
    chk(bus_rdata == 8'h80, "R7 been cleared", bus_rdata, 8'h80);
    // R11 handover during execution
    exec_busy = 1'b1;
    do_write(1, 0, 8'h02, "R4");
    do_write(3, 0, 8'h20, "R11");
    chk(last_cancel && owner_idx == 3'd3, "R11 held with cancel", owner_idx, 3);
    repeat (4) @(negedge clk);
    chk_owner("R11 still held");
    do_done("R11");
    chk(owner_idx == 3'd1 && last_irq, "R11 done completes", owner_idx, 1);
    do_write(2, 0, 8'h08, "R8");
    do_write(2, 0, 8'h08, "R8");
    chk(!last_cancel, "R8 repeat seize ignored", last_cancel, 0);
    do_write(0, 0, 8'h08, "R8");
    chk(!last_cancel, "R8 higher pending blocks", last_cancel, 0);
    do_write(3, 0, 8'h08, "R8");
    chk(last_cancel, "R8 higher seize accepted", last_cancel, 1);
    do_done("R8");
    do_read(1, 0, "R10");
    exec_busy = 1'b0;
    do_write(3, 0, 8'h20, "R8");
    chk(!owner_valid, "R8 lower seize cancelled", owner_valid, 0);
    // pseudo-random run against the model
    x = 32'h1ACE_B00C;
    for (int it = 0; it < 2500; it++) begin
      int op, l, v;
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      op = int'(x[2:0]);
      l  = int'(x[5:3]) % 6;
      v  = int'(x[15:8]);
      if (x[16]) v = v & 8'h3A;
      if (op < 5) do_write(l, x[17] && x[18] && x[19] ? 8 : 0, v, "R10 random");
      else if (op == 5) do_read(l, 0, "R3 random");
      else if (op == 6) begin @(negedge clk); exec_busy = ~exec_busy; end
      else do_done("R11 random");
      if (it % 16 == 0)
        for (int k = 0; k < 5; k++) do_read(k, 0, "R3 sweep");
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule